// File: doc/BRIEF.md
# Time-Multiplexed External Bus Bridge

This block turns single 16-bit internal accesses into activity on two 8-bit external lanes, an upper lane and a lower lane. Each lane carries an address byte first and a data byte after it. The internal requester pulses a request with an address, a write word and a direction flag. It then waits for a one-cycle acknowledge, which comes with the read word. Inside the block, every transfer is a full 16-bit word.

Three boot pins pick one of three layouts, and the block captures them while reset is held. In the 16-bit layout, one external cycle moves the whole word: the upper lane carries the high bytes and the lower lane carries the low bytes. In the 8-bit layout, data moves on the upper lane only, so one internal word takes two external cycles, high byte first. The lower lane keeps the low address byte during both cycles. In the no-bus layout nothing outside the chip is driven. A request there is answered at once with zero data.

Each external cycle has two phases. In the address phase the address strobe is high. In the data phase the strobe is low, and the lanes are driven for a write or released for a read.

Top module: `xbus_mux_if`

## Requirements
- R1: While rst_n is low the layout is taken from boot_mode_i on every clock edge. The value seen at the last edge with rst_n low is kept, and later changes on boot_mode_i have no effect. Encoding: 3'b111 or 3'b011 selects the 16-bit layout, 3'b101 or 3'b001 selects the 8-bit layout, and any other value selects no-bus.
- R2: During reset and whenever no transfer is running: ack_o=0, astb_o=0, up_oe_o=0, lo_oe_o=0 and xrd_o=1. Reset clears rdata_o to 0.
- R3: In the 16-bit layout a request seen high while the bridge is idle is taken at that clock edge. The next cycle is the address phase: astb_o=1, both lanes enabled, up_o=addr[15:8], lo_o=addr[7:0]. The data phase follows with astb_o=0.
- R4: For a 16-bit write, xrd_o=0 in both phases. In the data phase both lanes are enabled, with up_o=wdata[15:8] and lo_o=wdata[7:0].
- R5: For a 16-bit read, xrd_o=1 and both lanes are released in the data phase. The word {up_i, lo_i} present at the clock edge that ends the data phase becomes rdata_o.
- R6: In the 8-bit layout a transfer is two back-to-back external cycles (address, data, address, data). The first uses address addr and the second uses addr+1, wrapping at 16 bits. up_o carries the high address byte in each address phase. lo_o is enabled with the low address byte through both phases of each cycle.
- R7: For an 8-bit write the upper lane is enabled in both data phases. It carries wdata[15:8] in the first data phase and wdata[7:0] in the second.
- R8: For an 8-bit read the upper lane is released in both data phases. rdata_o becomes {up_i at the end of the first data phase, up_i at the end of the second}.
- R9: ack_o is high for exactly one cycle, the cycle right after the last data phase. rdata_o changes only in a cycle where ack_o is high, and a write leaves it unchanged.
- R10: In the no-bus layout a request gives ack_o=1 in the next cycle with rdata_o=0. The strobe never rises and no lane is ever enabled.
- R11: A request seen while a transfer is running is ignored. Address, write word and direction are captured when the request is taken, so later changes on them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode_i | input | 3 | Layout selection pins, captured during reset |
| req_i | input | 1 | One-cycle transfer request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Transfer address |
| wdata_i | input | 16 | Write word |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read word, valid with ack_o |
| up_o | output | 8 | Upper lane output value |
| up_oe_o | output | 1 | Upper lane output enable |
| up_i | input | 8 | Upper lane sampled value |
| lo_o | output | 8 | Lower lane output value |
| lo_oe_o | output | 1 | Lower lane output enable |
| lo_i | input | 8 | Lower lane sampled value |
| astb_o | output | 1 | Address strobe, high in address phases |
| xrd_o | output | 1 | External direction, 1 = read |

## Verification
Reads and writes with random addresses, words and returned lane bytes are run in each layout. Checking every phase cycle separates the high byte from the low byte, and the first byte cycle from the second. Fixed cases at address 16'hFFFF show that the second 8-bit cycle wraps to 16'h0000. Back-to-back requests, and stray requests with altered inputs raised in the middle of a transfer, show whether inputs are captured at acceptance and whether busy-time requests are dropped. Resets with pin values that change just before and just after release, including pin patterns whose top bit differs, confirm which value sets the layout.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus bridge: layout codes, phase codes
// and the boot-pin decoder. Assumes a three-pin boot code.
package xbus_pkg;

    typedef enum logic [1:0] {
        MODE_NOBUS = 2'd0,
        MODE_X8    = 2'd1,
        MODE_X16   = 2'd2
    } xmode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Map the three boot pins onto a bus layout; unlisted codes mean no bus.
    function automatic xmode_e decode_mode(input logic [2:0] pins);
        case (pins)
            3'b111, 3'b011: return MODE_X16;
            3'b101, 3'b001: return MODE_X8;
            default:        return MODE_NOBUS;
        endcase
    endfunction

endpackage

// File: rtl/xbus_mode_latch.sv
// Boot layout capture. Samples the pins on every edge while reset is
// held and keeps the last sample once reset is released.
// Assumes the pins are stable around the releasing edge.
module xbus_mode_latch
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] pins,
    output xmode_e     mode
);

    // Follow the pins during reset, freeze afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= decode_mode(pins);
        end
    end

endmodule

// File: rtl/xbus_seq.sv
// Phase sequencer. Walks address and data phases for one or two byte
// beats, depending on the layout, and raises the acknowledge after
// the final data phase. Assumes req is a one-cycle pulse per transfer.
module xbus_seq
    import xbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  xmode_e mode,
    input  logic   req,
    output phase_e phase,
    output logic   beat,
    output logic   accept,
    output logic   last,
    output logic   nobus_hit,
    output logic   ack
);

    // Decide when a request is taken and when the final data phase runs.
    always_comb begin
        accept    = (phase == PH_IDLE) && req && (mode != MODE_NOBUS);
        nobus_hit = (phase == PH_IDLE) && req && (mode == MODE_NOBUS);
        last      = (phase == PH_DATA) && ((mode == MODE_X16) || beat);
    end

    // Advance the phase, the beat index and the acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            beat  <= 1'b0;
            ack   <= 1'b0;
        end else begin
            ack <= last || nobus_hit;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase <= PH_ADDR;
                        beat  <= 1'b0;
                    end
                end
                PH_ADDR: phase <= PH_DATA;
                PH_DATA: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        phase <= PH_ADDR;
                        beat  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xbus_port_drv.sv
// Lane datapath. Holds the accepted request, drives address and write
// bytes onto the two lanes per phase, and assembles the read word.
// Assumes address and data are both twice the lane width.
module xbus_port_drv
    import xbus_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int AW    = 2 * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xmode_e            mode,
    input  phase_e            phase,
    input  logic              beat,
    input  logic              accept,
    input  logic              last,
    input  logic              nobus_hit,
    input  logic [AW-1:0]     addr_i,
    input  logic [AW-1:0]     wdata_i,
    input  logic              wr_i,
    input  logic [PORT_W-1:0] up_i,
    input  logic [PORT_W-1:0] lo_i,
    output logic [PORT_W-1:0] up_o,
    output logic              up_oe_o,
    output logic [PORT_W-1:0] lo_o,
    output logic              lo_oe_o,
    output logic              astb_o,
    output logic              xrd_o,
    output logic [AW-1:0]     rdata_o
);

    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     wdata_q;
    logic              wr_q;
    logic [PORT_W-1:0] rhi_q;
    logic [AW-1:0]     beat_addr;
    logic [PORT_W-1:0] wbyte;

    // Capture the request fields when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            wr_q    <= wr_i;
        end
    end

    // Per-beat address and write byte (high byte goes out first).
    always_comb begin
        beat_addr = addr_q + AW'(beat);
        wbyte     = beat ? wdata_q[PORT_W-1:0] : wdata_q[AW-1:PORT_W];
    end

    // Lane values, enables, strobe and direction for the current phase.
    always_comb begin
        up_o    = '0;
        lo_o    = '0;
        up_oe_o = 1'b0;
        lo_oe_o = 1'b0;
        astb_o  = 1'b0;
        xrd_o   = 1'b1;
        case (phase)
            PH_ADDR: begin
                astb_o  = 1'b1;
                xrd_o   = !wr_q;
                up_oe_o = 1'b1;
                lo_oe_o = 1'b1;
                up_o    = beat_addr[AW-1:PORT_W];
                lo_o    = beat_addr[PORT_W-1:0];
            end
            PH_DATA: begin
                xrd_o = !wr_q;
                if (mode == MODE_X16) begin
                    up_oe_o = wr_q;
                    lo_oe_o = wr_q;
                    up_o    = wr_q ? wdata_q[AW-1:PORT_W] : '0;
                    lo_o    = wr_q ? wdata_q[PORT_W-1:0] : '0;
                end else begin
                    up_oe_o = wr_q;
                    up_o    = wr_q ? wbyte : '0;
                    lo_oe_o = 1'b1;
                    lo_o    = beat_addr[PORT_W-1:0];
                end
            end
            default: begin
            end
        endcase
    end

    // Keep the first read byte of an 8-bit transfer until the second arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rhi_q <= '0;
        end else if ((phase == PH_DATA) && !wr_q && !beat && (mode == MODE_X8)) begin
            rhi_q <= up_i;
        end
    end

    // Publish the read word on the acknowledging edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (nobus_hit) begin
            rdata_o <= '0;
        end else if (last && !wr_q) begin
            rdata_o <= (mode == MODE_X16) ? {up_i, lo_i} : {rhi_q, up_i};
        end
    end

endmodule

// File: rtl/xbus_mux_if.sv
// Top of the external bus bridge. Joins the boot layout capture, the
// phase sequencer and the lane datapath. Assumes the requester pulses
// req_i for one cycle and waits for ack_o.
module xbus_mux_if
    import xbus_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            boot_mode_i,
    input  logic                  req_i,
    input  logic                  wr_i,
    input  logic [2*PORT_W-1:0]   addr_i,
    input  logic [2*PORT_W-1:0]   wdata_i,
    output logic                  ack_o,
    output logic [2*PORT_W-1:0]   rdata_o,
    output logic [PORT_W-1:0]     up_o,
    output logic                  up_oe_o,
    input  logic [PORT_W-1:0]     up_i,
    output logic [PORT_W-1:0]     lo_o,
    output logic                  lo_oe_o,
    input  logic [PORT_W-1:0]     lo_i,
    output logic                  astb_o,
    output logic                  xrd_o
);

    xmode_e mode_w;
    phase_e phase_w;
    logic   beat_w;
    logic   accept_w;
    logic   last_w;
    logic   nobus_w;

    xbus_mode_latch mode_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (boot_mode_i),
        .mode  (mode_w)
    );

    xbus_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_w),
        .req       (req_i),
        .phase     (phase_w),
        .beat      (beat_w),
        .accept    (accept_w),
        .last      (last_w),
        .nobus_hit (nobus_w),
        .ack       (ack_o)
    );

    xbus_port_drv #(.PORT_W(PORT_W)) drv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_w),
        .phase     (phase_w),
        .beat      (beat_w),
        .accept    (accept_w),
        .last      (last_w),
        .nobus_hit (nobus_w),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .wr_i      (wr_i),
        .up_i      (up_i),
        .lo_i      (lo_i),
        .up_o      (up_o),
        .up_oe_o   (up_oe_o),
        .lo_o      (lo_o),
        .lo_oe_o   (lo_oe_o),
        .astb_o    (astb_o),
        .xrd_o     (xrd_o),
        .rdata_o   (rdata_o)
    );

endmodule

// File: rtl/xbus_mux_if_chk.sv
// Protocol checker for the external bus bridge, bound to the top.
// Observes ports plus the captured layout; drives nothing.
module xbus_mux_if_chk
    import xbus_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input xmode_e              mode,
    input logic                ack_o,
    input logic [2*PORT_W-1:0] rdata_o,
    input logic                astb_o,
    input logic                up_oe_o,
    input logic                lo_oe_o,
    input logic                xrd_o
);

    // The captured layout never moves once reset has been released.
    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

    // An address phase always drives both lanes.
    p_strobe_drives_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        astb_o |-> (up_oe_o && lo_oe_o));

    // The strobe lasts one cycle and is followed by a data phase.
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        astb_o |=> !astb_o);

    // A write keeps the upper lane driven in every phase.
    p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xrd_o |-> up_oe_o);

    // Read data phases leave the upper lane released (R5 and R8).
    p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xrd_o && !astb_o) |-> !up_oe_o);

    // With an external layout the acknowledge is a single-cycle pulse.
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (mode != MODE_NOBUS)) |=> !ack_o);

    // The read word only changes together with an acknowledge.
    p_rdata_moves_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> ack_o);

    // Without a bus nothing outside is ever driven or strobed.
    p_nobus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NOBUS) |-> (!astb_o && !up_oe_o && !lo_oe_o));

endmodule

bind xbus_mux_if xbus_mux_if_chk #(.PORT_W(PORT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_w),
    .ack_o   (ack_o),
    .rdata_o (rdata_o),
    .astb_o  (astb_o),
    .up_oe_o (up_oe_o),
    .lo_oe_o (lo_oe_o),
    .xrd_o   (xrd_o)
);

// File: tb/xbus_mux_if_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random transfers
// in each layout, with per-phase expected lane values.
module xbus_mux_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  boot_mode;
    logic        req;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [7:0]  up_in;
    logic [7:0]  lo_in;
    logic        ack;
    logic [15:0] rdata;
    logic [7:0]  up_out;
    logic        up_oe;
    logic [7:0]  lo_out;
    logic        lo_oe;
    logic        astb;
    logic        xrd;

    int          total = 0;
    int          bad   = 0;
    bit          fin   = 1'b0;
    logic [15:0] exp_rdata;

    always #2 clk = ~clk;

    xbus_mux_if dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode_i (boot_mode),
        .req_i       (req),
        .wr_i        (wr),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .ack_o       (ack),
        .rdata_o     (rdata),
        .up_o        (up_out),
        .up_oe_o     (up_oe),
        .up_i        (up_in),
        .lo_o        (lo_out),
        .lo_oe_o     (lo_oe),
        .lo_i        (lo_in),
        .astb_o      (astb),
        .xrd_o       (xrd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] pk(input logic a, input logic uo, input logic lo,
                                       input logic rd, input logic [7:0] u, input logic [7:0] l);
        return {a, uo, lo, rd, u, l};
    endfunction

    function automatic logic [19:0] obs();
        return pk(astb, up_oe, lo_oe, xrd, up_oe ? up_out : 8'h00, lo_oe ? lo_out : 8'h00);
    endfunction

    function automatic logic [19:0] idle_pk();
        return pk(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    endfunction

    // Stray request with altered fields while busy (R11).
    task automatic junk();
        req   = 1'($urandom_range(0, 1));
        wr    = 1'($urandom_range(0, 1));
        addr  = 16'($urandom);
        wdata = 16'($urandom);
    endtask

    task automatic do_reset(input logic [2:0] pins);
        rst_n     = 1'b0;
        req       = 1'b0;
        boot_mode = ~pins;
        @(negedge clk);
        @(negedge clk);
        chk("R2 reset lanes", obs(), idle_pk());
        chk("R2 reset ack", ack, 0);
        chk("R2 reset rdata", rdata, 0);
        boot_mode = pins;
        @(negedge clk);
        rst_n     = 1'b1;
        boot_mode = ~pins;   // R1: late change must not matter
        @(negedge clk);
        chk("R2 idle after reset", obs(), idle_pk());
        exp_rdata = 16'h0000;
    endtask

    task automatic xfer_wide(input logic w, input logic [15:0] a, input logic [15:0] d,
                             input logic [15:0] rv);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        chk("R3 address phase", obs(), pk(1'b1, 1'b1, 1'b1, !w, a[15:8], a[7:0]));
        junk();
        up_in = w ? 8'($urandom) : rv[15:8];
        lo_in = w ? 8'($urandom) : rv[7:0];
        @(negedge clk);
        if (w) chk("R4 write data phase", obs(), pk(1'b0, 1'b1, 1'b1, 1'b0, d[15:8], d[7:0]));
        else   chk("R5 read data phase", obs(), pk(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00));
        chk("R9 no early ack", ack, 0);
        req = 1'b0;
        @(negedge clk);
        if (!w) exp_rdata = rv;
        chk("R9 ack pulse", ack, 1);
        if (w) chk("R9 write keeps rdata", rdata, exp_rdata);
        else   chk("R5 read word", rdata, exp_rdata);
        chk("R11 stray request dropped", astb, 0);
    endtask

    task automatic xfer_narrow(input logic w, input logic [15:0] a, input logic [15:0] d,
                               input logic [15:0] rv);
        logic [15:0] a1;
        a1  = a + 16'd1;
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        chk("R6 first address phase", obs(), pk(1'b1, 1'b1, 1'b1, !w, a[15:8], a[7:0]));
        junk();
        up_in = w ? 8'($urandom) : rv[15:8];
        lo_in = 8'($urandom);
        @(negedge clk);
        if (w) chk("R7 first data byte", obs(), pk(1'b0, 1'b1, 1'b1, 1'b0, d[15:8], a[7:0]));
        else   chk("R8 first read phase", obs(), pk(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, a[7:0]));
        junk();
        @(negedge clk);
        chk("R6 second address phase", obs(), pk(1'b1, 1'b1, 1'b1, !w, a1[15:8], a1[7:0]));
        chk("R9 no ack between beats", ack, 0);
        junk();
        up_in = w ? 8'($urandom) : rv[7:0];
        @(negedge clk);
        if (w) chk("R7 second data byte", obs(), pk(1'b0, 1'b1, 1'b1, 1'b0, d[7:0], a1[7:0]));
        else   chk("R8 second read phase", obs(), pk(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, a1[7:0]));
        req = 1'b0;
        @(negedge clk);
        if (!w) exp_rdata = rv;
        chk("R9 ack pulse narrow", ack, 1);
        if (w) chk("R9 write keeps rdata", rdata, exp_rdata);
        else   chk("R8 read word", rdata, exp_rdata);
        chk("R11 stray request dropped", astb, 0);
    endtask

    task automatic xfer_nobus(input logic w, input logic [15:0] a, input logic [15:0] d);
        req = 1'b1; wr = w; addr = a; wdata = d;
        up_in = 8'($urandom); lo_in = 8'($urandom);
        @(negedge clk);
        req = 1'b0;
        exp_rdata = 16'h0000;
        chk("R10 immediate ack", ack, 1);
        chk("R10 zero read word", rdata, exp_rdata);
        chk("R10 lanes quiet", obs(), idle_pk());
        @(negedge clk);
        chk("R10 ack drops", ack, 0);
        chk("R10 lanes stay quiet", obs(), idle_pk());
    endtask

    initial begin
        void'($urandom(32'd7719));
        req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; up_in = '0; lo_in = '0;
        boot_mode = 3'b000;

        // 16-bit layout, top pin low (R1)
        do_reset(3'b011);
        xfer_wide(1'b1, 16'h1234, 16'hABCD, 16'h0000);
        xfer_wide(1'b0, 16'h8001, 16'h0000, 16'h5A3C);
        xfer_wide(1'b1, 16'hFFFF, 16'h0F0F, 16'h0000);
        for (int i = 0; i < 25; i++) begin
            xfer_wide(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom), 16'($urandom));
        end

        // 8-bit layout with address wrap corners
        do_reset(3'b101);
        xfer_narrow(1'b1, 16'hFFFF, 16'hBEEF, 16'h0000);
        xfer_narrow(1'b0, 16'hFFFF, 16'h0000, 16'hC3A5);
        xfer_narrow(1'b0, 16'h2000, 16'h0000, 16'h00FF);
        for (int i = 0; i < 25; i++) begin
            xfer_narrow(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom), 16'($urandom));
        end

        // No-bus layout: both reads and writes
        do_reset(3'b100);
        for (int i = 0; i < 6; i++) begin
            xfer_nobus(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom));
        end

        // Other encodings of the same layouts (R1)
        do_reset(3'b111);
        xfer_wide(1'b0, 16'h4321, 16'h0000, 16'h9966);
        do_reset(3'b001);
        xfer_narrow(1'b0, 16'h00FE, 16'h0000, 16'h7E81);
        do_reset(3'b110);
        xfer_nobus(1'b0, 16'h1111, 16'h2222);

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule